// File: doc/BRIEF.md
# Single-Bank Row Buffer Access Sequencer

This block stands in for one DRAM bank with one row buffer. It takes one access at a time over a valid/ready handshake, with a row and a column address. It keeps track of whether the row buffer is empty or open, and which row an open buffer holds. From that state it runs the needed phases in order: precharge, then activate, then column. Each phase lasts a fixed number of clock cycles.

When an access ends, the block gives a one-cycle completion pulse. With the pulse it reports:
- the outcome class of the access,
- the row and column it served,
- the number of cycles from acceptance to completion.

A static policy input chooses between two behaviours:
- **Keep-open:** the row stays in the buffer after each access.
- **Auto-close:** a background precharge follows each access and empties the buffer. The bank stays busy for that time.

With the default timing at a 10 ns clock, each phase is 20 ns. A hit therefore costs 20 ns, an empty-buffer access 40 ns and a conflict 60 ns.

Top module: `bank_rowbuf_ctrl`

## Requirements
- R1: After synchronous reset, `req_ready` is high, `done` is low and the row buffer is empty, so the first access is classed as empty.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after that edge and stays low while the bank is busy.
- R3: An access to the row already open is a hit, outcome code 0. `done` is high T_COL cycles (default 2) after the accept edge.
- R4: An access while the buffer is empty is outcome code 1. It costs T_ACT + T_COL cycles (default 4).
- R5: An access to a different row than the open one is a conflict, outcome code 2. It costs T_PRE + T_ACT + T_COL cycles (default 6). Code 3 never appears.
- R6: When the keep-open policy (`close_page` = 0) is sampled at acceptance, the row remains open after the access and `req_ready` is high in the `done` cycle.
- R7: When the auto-close policy (`close_page` = 1) is sampled at acceptance, a background precharge of T_PRE cycles follows `done`. `req_ready` is low during that precharge and the next access is classed as empty.
- R8: `done` is high for exactly one cycle per accepted request. In that cycle `done_row` and `done_col` equal the addresses of that request.
- R9: `done_lat` equals the cycle count from the accept edge to the edge that raises `done`.
- R10: A request held valid while the bank is busy is not taken early. It is accepted once, when the bank returns to idle, and yields exactly one completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| close_page | input | 1 | Policy select: 0 keep-open, 1 auto-close; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank idle and able to take a request |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| done | output | 1 | One-cycle completion pulse |
| done_outcome | output | 2 | 0 hit, 1 empty, 2 conflict |
| done_row | output | ROW_W | Row of the completed request |
| done_col | output | COL_W | Column of the completed request |
| done_lat | output | LAT_W | Cycles from acceptance to completion |

## Verification
`done` rises on the edge that lies T_COL, T_ACT + T_COL or T_PRE + T_ACT + T_COL edges after the accept edge, depending on the outcome class. `req_ready` comes back on that same edge under keep-open, and T_PRE edges later under auto-close.

The bench counts clock edges itself. It records the count just before each accept edge, and its monitor samples at the falling edge. When `done` is seen, the monitor compares the elapsed count with the latency its own row-buffer model predicts. Under auto-close it also follows `req_ready` over the next falling edges to confirm the length of the background precharge.

// File: rtl/bank_pkg.sv
package bank_pkg;

    typedef enum logic [1:0] {
        OUT_HIT      = 2'd0,
        OUT_EMPTY    = 2'd1,
        OUT_CONFLICT = 2'd2
    } outcome_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_ACT,
        PH_COL,
        PH_BGPRE
    } phase_e;

    function automatic outcome_e classify(input logic is_open, input logic row_match);
        if (!is_open)
            return OUT_EMPTY;
        else if (row_match)
            return OUT_HIT;
        else
            return OUT_CONFLICT;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bank_phase_timer.sv
module bank_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
    import bank_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] lookup_row,
    input  logic             set_open,
    input  logic [ROW_W-1:0] set_row,
    input  logic             set_closed,
    output outcome_e         lookup_class
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (set_open) begin
            open_q <= 1'b1;
            row_q  <= set_row;
        end else if (set_closed) begin
            open_q <= 1'b0;
        end
    end

    assign lookup_class = classify(open_q, row_q == lookup_row);

    AST_NO_SET_AND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !(set_open && set_closed)); // R7

endmodule

// File: rtl/bank_rowbuf_ctrl.sv
module bank_rowbuf_ctrl
    import bank_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 10,
    parameter int T_PRE = 2,
    parameter int T_ACT = 2,
    parameter int T_COL = 2,
    localparam int LAT_MAX = T_PRE + T_ACT + T_COL,
    localparam int LAT_W   = $clog2(LAT_MAX + 1),
    localparam int CW      = $clog2(max3(T_PRE, T_ACT, T_COL)) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             close_page,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             done,
    output logic [1:0]       done_outcome,
    output logic [ROW_W-1:0] done_row,
    output logic [COL_W-1:0] done_col,
    output logic [LAT_W-1:0] done_lat
);
    localparam logic [CW-1:0]    LD_PRE = CW'(T_PRE - 1);
    localparam logic [CW-1:0]    LD_ACT = CW'(T_ACT - 1);
    localparam logic [CW-1:0]    LD_COL = CW'(T_COL - 1);
    localparam logic [LAT_W-1:0] L_HIT  = LAT_W'(T_COL);
    localparam logic [LAT_W-1:0] L_EMP  = LAT_W'(T_ACT + T_COL);
    localparam logic [LAT_W-1:0] L_CON  = LAT_W'(LAT_MAX);

    phase_e           phase, phase_nxt;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             pol_q;
    outcome_e         outc_q;
    logic [LAT_W-1:0] elapsed;
    outcome_e         done_outc_q;

    logic             accept;
    logic             t_load;
    logic [CW-1:0]    t_val;
    logic             t_expired;
    logic             trk_open, trk_close;
    logic             fin;
    outcome_e         cls;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    bank_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    bank_row_tracker #(.ROW_W(ROW_W)) u_tracker (
        .clk          (clk),
        .rst          (rst),
        .lookup_row   (req_row),
        .set_open     (trk_open),
        .set_row      (row_q),
        .set_closed   (trk_close),
        .lookup_class (cls)
    );

    always_comb begin
        phase_nxt = phase;
        t_load    = 1'b0;
        t_val     = '0;
        trk_open  = 1'b0;
        trk_close = 1'b0;
        fin       = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (accept) begin
                    t_load = 1'b1;
                    unique case (cls)
                        OUT_HIT:   begin phase_nxt = PH_COL; t_val = LD_COL; end
                        OUT_EMPTY: begin phase_nxt = PH_ACT; t_val = LD_ACT; end
                        default:   begin phase_nxt = PH_PRE; t_val = LD_PRE; end
                    endcase
                end
            end
            PH_PRE: begin
                if (t_expired) begin
                    trk_close = 1'b1;
                    phase_nxt = PH_ACT;
                    t_load    = 1'b1;
                    t_val     = LD_ACT;
                end
            end
            PH_ACT: begin
                if (t_expired) begin
                    trk_open  = 1'b1;
                    phase_nxt = PH_COL;
                    t_load    = 1'b1;
                    t_val     = LD_COL;
                end
            end
            PH_COL: begin
                if (t_expired) begin
                    fin = 1'b1;
                    if (pol_q) begin
                        phase_nxt = PH_BGPRE;
                        t_load    = 1'b1;
                        t_val     = LD_PRE;
                    end else begin
                        phase_nxt = PH_IDLE;
                    end
                end
            end
            PH_BGPRE: begin
                if (t_expired) begin
                    trk_close = 1'b1;
                    phase_nxt = PH_IDLE;
                end
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            row_q       <= '0;
            col_q       <= '0;
            pol_q       <= 1'b0;
            outc_q      <= OUT_EMPTY;
            elapsed     <= '0;
            done        <= 1'b0;
            done_outc_q <= OUT_HIT;
            done_row    <= '0;
            done_col    <= '0;
            done_lat    <= '0;
        end else begin
            phase <= phase_nxt;
            done  <= fin;
            if (accept) begin
                row_q   <= req_row;
                col_q   <= req_col;
                pol_q   <= close_page;
                outc_q  <= cls;
                elapsed <= LAT_W'(1);
            end else if (phase == PH_PRE || phase == PH_ACT || phase == PH_COL) begin
                elapsed <= elapsed + 1'b1;
            end
            if (fin) begin
                done_outc_q <= outc_q;
                done_row    <= row_q;
                done_col    <= col_q;
                done_lat    <= elapsed;
            end
        end
    end

    assign done_outcome = done_outc_q;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !done)); // R1
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready); // R2
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_outcome != 2'd3)); // R5
    AST_OPEN_READY: assert property (@(posedge clk) disable iff (rst)
        (done && !pol_q) |-> req_ready); // R6
    AST_CLOSE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (done && pol_q) |-> !req_ready); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_LAT_MATCH: assert property (@(posedge clk) disable iff (rst)
        done |-> ((done_outcome == 2'd0 && done_lat == L_HIT) ||
                  (done_outcome == 2'd1 && done_lat == L_EMP) ||
                  (done_outcome == 2'd2 && done_lat == L_CON))); // R9

endmodule

// File: tb/bank_rowbuf_ctrl_bench.sv
module bank_rowbuf_ctrl_bench;
    localparam int ROW_W = 12;
    localparam int COL_W = 10;
    localparam int LAT_W = 3;

    typedef struct {
        int outcome;
        int row;
        int col;
        int lat;
        bit closep;
        int tpre;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             close_page = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             done;
    logic [1:0]       done_outcome;
    logic [ROW_W-1:0] done_row;
    logic [COL_W-1:0] done_col;
    logic [LAT_W-1:0] done_lat;

    int   nchk = 0;
    int   nerr = 0;
    int   cyc = 0;
    int   sent = 0;
    int   seen = 0;
    bit   m_open = 1'b0;
    int   m_row = 0;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bank_rowbuf_ctrl u_bank_rowbuf_ctrl (
        .clk, .rst, .close_page, .req_valid, .req_ready, .req_row, .req_col,
        .done, .done_outcome, .done_row, .done_col, .done_lat
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input int row, input int col);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        while (!req_ready) @(negedge clk);
        e.row    = row;
        e.col    = col;
        e.closep = close_page;
        e.tpre   = cyc;
        if (!m_open)          begin e.outcome = 1; e.lat = 4; end
        else if (m_row == row) begin e.outcome = 0; e.lat = 2; end
        else                  begin e.outcome = 2; e.lat = 6; end
        m_open = !close_page;
        m_row  = row;
        q.push_back(e);
        sent++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                exp_t e;
                seen++;
                if (q.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    e = q.pop_front();
                    case (e.outcome)
                        0: chk(done_outcome == 2'd0, "R3 hit code", done_outcome, 0);
                        1: chk(done_outcome == 2'd1, "R4 empty code", done_outcome, 1);
                        default: chk(done_outcome == 2'd2, "R5 conflict code", done_outcome, 2);
                    endcase
                    chk(cyc - e.tpre - 1 == e.lat, "R3/R4/R5 timing", cyc - e.tpre - 1, e.lat);
                    chk(int'(done_lat) == e.lat, "R9 done_lat", done_lat, e.lat);
                    chk(int'(done_row) == e.row, "R8 row echo", done_row, e.row);
                    chk(int'(done_col) == e.col, "R8 col echo", done_col, e.col);
                    if (!e.closep) begin
                        chk(req_ready == 1'b1, "R6 ready at done", req_ready, 1);
                    end else begin
                        chk(req_ready == 1'b0, "R7 busy at done", req_ready, 0);
                        @(negedge clk);
                        chk(done == 1'b0, "R8 single pulse", done, 0);
                        chk(req_ready == 1'b0, "R7 busy in precharge", req_ready, 0);
                        @(negedge clk);
                        chk(req_ready == 1'b1, "R7 idle after precharge", req_ready, 1);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(done == 1'b0, "R1 done low after reset", done, 0);
        // R1: first access empty; R4, R3, R5 under keep-open (R6)
        send(5, 1);
        send(5, 2);
        send(5, 3);
        send(9, 0);
        send(9, 7);
        send(5, 4);
        // R7: auto-close; R10 requests held valid during busy time
        close_page = 1'b1;
        send(5, 5);
        send(5, 6);
        send(9, 1);
        close_page = 1'b0;
        send(3, 3);
        send(3, 4);
        send(4095, 1023);
        send(4095, 0);
        send(0, 0);
        while (q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(seen == sent, "R10 one completion per request", seen, sent);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule